// File: doc/BRIEF.md
# Bidirectional FIFO pointer unit with mark and restore

This block keeps the read and write pointers for two independent FIFOs of 18-bit words that carry data in opposite directions between two ports, A and B. The A-to-B queue is written by port A and read by port B. The B-to-A queue is written by port B and read by port A. The block turns the push and pop strobes of both ports into memory addresses and reports the empty and full state of each queue. The word storage is a separate simple dual-port memory that these addresses drive.

Each direction also holds a saved copy of one pointer. The A-to-B queue can save its read position and return to it later, so a block of words can be read again. The B-to-A queue can save its write position and return to it, so a block of words can be written again. A 4-bit command input can save or restore these marks, advance the marked-side pointer without moving data, or clear either queue. Every pointer carries an extra wrap bit, so that a full queue and an empty queue remain distinct after a restore.

Top module: `bififo_ptr_unit`

## Requirements
- R1: A synchronous hardware reset (`rst` high at a clock edge) sets all four pointers and both saved pointers to zero. After it both queues read empty and not full, with all addresses zero.
- R2: A push to a queue that is not full advances its write address by one. A pop from a queue that is not empty advances its read address by one. Addresses wrap modulo DEPTH.
- R3: A push to a full queue and a pop from an empty queue are ignored and leave the pointers unchanged.
- R4: A queue is empty when its read and write pointers are equal, including the wrap bit. It is full when they differ by exactly DEPTH, so after DEPTH pushes with no pops the queue reads full and not empty.
- R5: Command 4'h4 copies the current A-to-B read pointer, including its wrap bit, into the A-to-B saved pointer.
- R6: Command 4'h5 copies the current B-to-A write pointer, including its wrap bit, into the B-to-A saved pointer.
- R7: Command 4'h6 loads the A-to-B read pointer from its saved pointer. Command 4'h7 loads the B-to-A write pointer from its saved pointer.
- R8: When a restore and a transfer on the same pointer fall in the same cycle, the restore takes effect and the transfer is dropped.
- R9: Command 4'h8 advances the A-to-B read pointer by one if that queue is not empty. Command 4'h9 advances the B-to-A write pointer by one if that queue is not full. Neither moves data.
- R10: Command 4'h1 clears the B-to-A read, write and saved pointers. Command 4'h2 clears the A-to-B read, write and saved pointers. Command 4'h3 clears both sets. A clear overrides any push or pop on that queue in the same cycle.
- R11: Command codes 4'h0 and 4'hA to 4'hF have no effect on any pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ab_push | input | 1 | Port A writes one word into the A-to-B queue |
| ab_pop | input | 1 | Port B reads one word from the A-to-B queue |
| ba_push | input | 1 | Port B writes one word into the B-to-A queue |
| ba_pop | input | 1 | Port A reads one word from the B-to-A queue |
| cmd_op | input | 4 | Pointer command code, 4'h0 when idle |
| ab_wr_addr | output | log2(DEPTH) | A-to-B memory write address |
| ab_rd_addr | output | log2(DEPTH) | A-to-B memory read address |
| ab_empty | output | 1 | A-to-B queue holds no words |
| ab_full | output | 1 | A-to-B queue holds DEPTH words |
| ba_wr_addr | output | log2(DEPTH) | B-to-A memory write address |
| ba_rd_addr | output | log2(DEPTH) | B-to-A memory read address |
| ba_empty | output | 1 | B-to-A queue holds no words |
| ba_full | output | 1 | B-to-A queue holds DEPTH words |

## Verification
The bench builds the block with DEPTH at 512, the smaller of the two supported sizes. At this size a queue can be filled and drained within a few thousand cycles. That puts the full flag, the address wrap and the wrap-bit distinction within reach. A restore of a read mark saved before a complete drain must bring back a full queue, not an empty one. A short vector table covers marks, restores, steps, clears and their same-cycle priorities. Directed runs then cover the full queues and a hardware reset taken while a mark is held.

// File: rtl/fifo_ptr_pkg.sv
package fifo_ptr_pkg;

    localparam int N_DIR  = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    typedef enum logic [3:0] {
        OP_NONE       = 4'h0,
        OP_CLR_BA     = 4'h1,
        OP_CLR_AB     = 4'h2,
        OP_CLR_ALL    = 4'h3,
        OP_MARK_AB_RD = 4'h4,
        OP_MARK_BA_WR = 4'h5,
        OP_BACK_AB_RD = 4'h6,
        OP_BACK_BA_WR = 4'h7,
        OP_STEP_AB_RD = 4'h8,
        OP_STEP_BA_WR = 4'h9
    } ptr_op_e;

    // Per-direction control strobes after command decode
    typedef struct packed {
        logic push;
        logic pop;
        logic clr;
        logic mark;
        logic back;
        logic step;
    } dir_ctl_t;

    function automatic dir_ctl_t decode_dir(input logic [3:0] op,
                                            input logic       is_ba,
                                            input logic       push,
                                            input logic       pop);
        dir_ctl_t c;
        c.push = push;
        c.pop  = pop;
        if (is_ba) begin
            c.clr  = (op == OP_CLR_BA) || (op == OP_CLR_ALL);
            c.mark = (op == OP_MARK_BA_WR);
            c.back = (op == OP_BACK_BA_WR);
            c.step = (op == OP_STEP_BA_WR);
        end else begin
            c.clr  = (op == OP_CLR_AB) || (op == OP_CLR_ALL);
            c.mark = (op == OP_MARK_AB_RD);
            c.back = (op == OP_BACK_AB_RD);
            c.step = (op == OP_STEP_AB_RD);
        end
        return c;
    endfunction

endpackage

// File: rtl/ptr_cmd_decode.sv
module ptr_cmd_decode
    import fifo_ptr_pkg::*;
(
    input  logic [3:0]                  cmd_op,
    input  logic [N_DIR-1:0]            push,
    input  logic [N_DIR-1:0]            pop,
    output dir_ctl_t [N_DIR-1:0]        ctl
);

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        assign ctl[d] = decode_dir(cmd_op, (d == DIR_BA), push[d], pop[d]);
    end

endmodule

// File: rtl/dir_ptrs.sv
module dir_ptrs
    import fifo_ptr_pkg::*;
#(
    parameter int DEPTH   = 512,
    parameter bit MARK_WR = 1'b0   // 1: mark tracks write pointer, 0: read pointer
) (
    input  logic                         clk,
    input  logic                         rst,
    input  dir_ctl_t                     ctl,
    output logic [$clog2(DEPTH)-1:0]     wr_addr,
    output logic [$clog2(DEPTH)-1:0]     rd_addr,
    output logic                         empty,
    output logic                         full
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_q, rd_q, mark_q;
    logic [PW-1:0] mark_src;
    logic          wr_adv, rd_adv, wr_back, rd_back;

    assign empty = (wr_q == rd_q);
    assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);

    if (MARK_WR) begin : g_mark_wr
        assign mark_src = wr_q;
        assign wr_adv   = (ctl.push || ctl.step) && !full;
        assign rd_adv   = ctl.pop && !empty;
        assign wr_back  = ctl.back;
        assign rd_back  = 1'b0;
    end else begin : g_mark_rd
        assign mark_src = rd_q;
        assign wr_adv   = ctl.push && !full;
        assign rd_adv   = (ctl.pop || ctl.step) && !empty;
        assign wr_back  = 1'b0;
        assign rd_back  = ctl.back;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            wr_q   <= '0;
            rd_q   <= '0;
            mark_q <= '0;
        end else begin
            if (wr_back)     wr_q <= mark_q;
            else if (wr_adv) wr_q <= wr_q + PW'(1);
            if (rd_back)     rd_q <= mark_q;
            else if (rd_adv) rd_q <= rd_q + PW'(1);
            if (ctl.mark)    mark_q <= mark_src;
        end
    end

    assign wr_addr = wr_q[AW-1:0];
    assign rd_addr = rd_q[AW-1:0];

endmodule

// File: rtl/bififo_ptr_unit.sv
module bififo_ptr_unit
    import fifo_ptr_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ab_push,
    input  logic                      ab_pop,
    input  logic                      ba_push,
    input  logic                      ba_pop,
    input  logic [3:0]                cmd_op,
    output logic [$clog2(DEPTH)-1:0]  ab_wr_addr,
    output logic [$clog2(DEPTH)-1:0]  ab_rd_addr,
    output logic                      ab_empty,
    output logic                      ab_full,
    output logic [$clog2(DEPTH)-1:0]  ba_wr_addr,
    output logic [$clog2(DEPTH)-1:0]  ba_rd_addr,
    output logic                      ba_empty,
    output logic                      ba_full
);

    localparam int AW = $clog2(DEPTH);

    dir_ctl_t [N_DIR-1:0] ctl;
    logic [N_DIR-1:0]     push_v, pop_v;
    logic [AW-1:0]        wa [N_DIR];
    logic [AW-1:0]        ra [N_DIR];
    logic [N_DIR-1:0]     emp, ful;

    assign push_v[DIR_AB] = ab_push;
    assign push_v[DIR_BA] = ba_push;
    assign pop_v[DIR_AB]  = ab_pop;
    assign pop_v[DIR_BA]  = ba_pop;

    ptr_cmd_decode u_dec (
        .cmd_op (cmd_op),
        .push   (push_v),
        .pop    (pop_v),
        .ctl    (ctl)
    );

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        dir_ptrs #(
            .DEPTH   (DEPTH),
            .MARK_WR (d == DIR_BA)
        ) u_ptrs (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl[d]),
            .wr_addr (wa[d]),
            .rd_addr (ra[d]),
            .empty   (emp[d]),
            .full    (ful[d])
        );
    end

    assign ab_wr_addr = wa[DIR_AB];
    assign ab_rd_addr = ra[DIR_AB];
    assign ab_empty   = emp[DIR_AB];
    assign ab_full    = ful[DIR_AB];
    assign ba_wr_addr = wa[DIR_BA];
    assign ba_rd_addr = ra[DIR_BA];
    assign ba_empty   = emp[DIR_BA];
    assign ba_full    = ful[DIR_BA];

endmodule

// File: rtl/bififo_ptr_chk.sv
module bififo_ptr_chk #(
    parameter int DEPTH = 512
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ab_push,
    input logic                      ab_pop,
    input logic                      ba_push,
    input logic                      ba_pop,
    input logic [3:0]                cmd_op,
    input logic [$clog2(DEPTH)-1:0]  ab_wr_addr,
    input logic [$clog2(DEPTH)-1:0]  ab_rd_addr,
    input logic                      ab_empty,
    input logic                      ab_full,
    input logic [$clog2(DEPTH)-1:0]  ba_wr_addr,
    input logic [$clog2(DEPTH)-1:0]  ba_rd_addr,
    input logic                      ba_empty,
    input logic                      ba_full
);

    localparam int AW = $clog2(DEPTH);

    logic clr_ab, clr_ba, quiet;
    assign clr_ab = (cmd_op == 4'h2) || (cmd_op == 4'h3);
    assign clr_ba = (cmd_op == 4'h1) || (cmd_op == 4'h3);
    assign quiet  = !ab_push && !ab_pop && !ba_push && !ba_pop;

    // R1
    hw_reset_clears_chk: assert property (@(posedge clk)
        rst |=> (ab_wr_addr == '0) && (ab_rd_addr == '0) && ab_empty && !ab_full &&
                (ba_wr_addr == '0) && (ba_rd_addr == '0) && ba_empty && !ba_full);

    // R2
    ab_push_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_push && !ab_full && !clr_ab) |=> (ab_wr_addr == AW'($past(ab_wr_addr) + 1'b1)));

    // R3
    ab_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_push && ab_full && !clr_ab) |=> $stable(ab_wr_addr));

    // R3
    ba_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ba_pop && ba_empty && !clr_ba) |=> $stable(ba_rd_addr));

    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(ab_full && ab_empty) && !(ba_full && ba_empty));

    // R10
    ab_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_ab |=> (ab_wr_addr == '0) && (ab_rd_addr == '0) && ab_empty);

    // R10
    ba_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_ba |=> (ba_wr_addr == '0) && (ba_rd_addr == '0) && ba_empty);

    // R11
    idle_code_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (quiet && ((cmd_op == 4'h0) || (cmd_op >= 4'hA))) |=>
            $stable(ab_wr_addr) && $stable(ab_rd_addr) && $stable(ab_full) &&
            $stable(ba_wr_addr) && $stable(ba_rd_addr) && $stable(ba_full));

endmodule

bind bififo_ptr_unit bififo_ptr_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_bififo_ptr_unit.sv
`timescale 1ns/1ps
module tb_bififo_ptr_unit;

    localparam int DEPTH = 512;
    localparam int AW    = 9;
    localparam int NV    = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ab_push = 1'b0, ab_pop = 1'b0, ba_push = 1'b0, ba_pop = 1'b0;
    logic [3:0]    cmd_op = 4'h0;
    logic [AW-1:0] ab_wr_addr, ab_rd_addr, ba_wr_addr, ba_rd_addr;
    logic          ab_empty, ab_full, ba_empty, ba_full;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bififo_ptr_unit #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst),
        .ab_push(ab_push), .ab_pop(ab_pop), .ba_push(ba_push), .ba_pop(ba_pop),
        .cmd_op(cmd_op),
        .ab_wr_addr(ab_wr_addr), .ab_rd_addr(ab_rd_addr),
        .ab_empty(ab_empty), .ab_full(ab_full),
        .ba_wr_addr(ba_wr_addr), .ba_rd_addr(ba_rd_addr),
        .ba_empty(ba_empty), .ba_full(ba_full)
    );

    // {ab_push, ab_pop, ba_push, ba_pop, op, ab_wr, ab_rd, ab_e, ab_f, ba_wr, ba_rd, ba_e, ba_f}
    localparam logic [47:0] VEC [NV] = '{
        {4'b1000, 4'h0, 9'd1, 9'd0, 1'b0, 1'b0, 9'd0, 9'd0, 1'b1, 1'b0}, // R2
        {4'b1010, 4'h0, 9'd2, 9'd0, 1'b0, 1'b0, 9'd1, 9'd0, 1'b0, 1'b0}, // R2
        {4'b0100, 4'h4, 9'd2, 9'd1, 1'b0, 1'b0, 9'd1, 9'd0, 1'b0, 1'b0}, // R5 mark at 0
        {4'b0100, 4'h0, 9'd2, 9'd2, 1'b1, 1'b0, 9'd1, 9'd0, 1'b0, 1'b0}, // R2 R4
        {4'b0100, 4'h0, 9'd2, 9'd2, 1'b1, 1'b0, 9'd1, 9'd0, 1'b0, 1'b0}, // R3 pop empty
        {4'b0000, 4'h6, 9'd2, 9'd0, 1'b0, 1'b0, 9'd1, 9'd0, 1'b0, 1'b0}, // R7
        {4'b0100, 4'h6, 9'd2, 9'd0, 1'b0, 1'b0, 9'd1, 9'd0, 1'b0, 1'b0}, // R8
        {4'b0010, 4'h5, 9'd2, 9'd0, 1'b0, 1'b0, 9'd2, 9'd0, 1'b0, 1'b0}, // R6 mark at 1
        {4'b0011, 4'h0, 9'd2, 9'd0, 1'b0, 1'b0, 9'd3, 9'd1, 1'b0, 1'b0}, // R2
        {4'b0000, 4'h7, 9'd2, 9'd0, 1'b0, 1'b0, 9'd1, 9'd1, 1'b1, 1'b0}, // R7
        {4'b0000, 4'h9, 9'd2, 9'd0, 1'b0, 1'b0, 9'd2, 9'd1, 1'b0, 1'b0}, // R9
        {4'b0000, 4'h8, 9'd2, 9'd1, 1'b0, 1'b0, 9'd2, 9'd1, 1'b0, 1'b0}, // R9
        {4'b0000, 4'hB, 9'd2, 9'd1, 1'b0, 1'b0, 9'd2, 9'd1, 1'b0, 1'b0}, // R11
        {4'b0000, 4'h1, 9'd2, 9'd1, 1'b0, 1'b0, 9'd0, 9'd0, 1'b1, 1'b0}, // R10
        {4'b0000, 4'h7, 9'd2, 9'd1, 1'b0, 1'b0, 9'd0, 9'd0, 1'b1, 1'b0}, // R10 mark cleared
        {4'b0000, 4'h4, 9'd2, 9'd1, 1'b0, 1'b0, 9'd0, 9'd0, 1'b1, 1'b0}, // R5 mark at 1
        {4'b1000, 4'h2, 9'd0, 9'd0, 1'b1, 1'b0, 9'd0, 9'd0, 1'b1, 1'b0}, // R10 clear beats push
        {4'b0000, 4'h6, 9'd0, 9'd0, 1'b1, 1'b0, 9'd0, 9'd0, 1'b1, 1'b0}, // R10 mark cleared
        {4'b0000, 4'h8, 9'd0, 9'd0, 1'b1, 1'b0, 9'd0, 9'd0, 1'b1, 1'b0}, // R9 step on empty
        {4'b0101, 4'h0, 9'd0, 9'd0, 1'b1, 1'b0, 9'd0, 9'd0, 1'b1, 1'b0}  // R3 pops on empty
    };

    function automatic logic [39:0] obs();
        return {ab_wr_addr, ab_rd_addr, ab_empty, ab_full,
                ba_wr_addr, ba_rd_addr, ba_empty, ba_full};
    endfunction

    function automatic logic [39:0] st(input int abw, input int abr, input logic abe,
                                       input logic abf, input int baw, input int bar,
                                       input logic bae, input logic baf);
        return {AW'(abw), AW'(abr), abe, abf, AW'(baw), AW'(bar), bae, baf};
    endfunction

    task automatic chk(input string what, input logic [39:0] exp);
        logic [39:0] got;
        got = obs();
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, got, exp);
        end
    endtask

    task automatic cyc(input logic apu, input logic apo, input logic bpu,
                       input logic bpo, input logic [3:0] op);
        ab_push = apu; ab_pop = apo; ba_push = bpu; ba_pop = bpo; cmd_op = op;
        @(posedge clk);
        @(negedge clk);
        ab_push = 1'b0; ab_pop = 1'b0; ba_push = 1'b0; ba_pop = 1'b0; cmd_op = 4'h0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        do_reset();
        chk("R1 state after reset", st(0, 0, 1, 0, 0, 0, 1, 0));

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][47], VEC[i][46], VEC[i][45], VEC[i][44], VEC[i][43:40]);
            chk($sformatf("vector row %0d", i), VEC[i][39:0]);
        end

        // R4: fill A-to-B, addresses wrap to zero but queue is full
        do_reset();
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, 0, 4'h0);
        chk("R4 full after DEPTH pushes", st(0, 0, 0, 1, 0, 0, 1, 0));
        cyc(1, 0, 0, 0, 4'h0);
        chk("R3 push while full ignored", st(0, 0, 0, 1, 0, 0, 1, 0));
        cyc(0, 0, 0, 0, 4'h4);
        for (int i = 0; i < DEPTH; i++) cyc(0, 1, 0, 0, 4'h0);
        chk("R2 drained after DEPTH pops", st(0, 0, 1, 0, 0, 0, 1, 0));
        cyc(0, 0, 0, 0, 4'h6);
        chk("R5 restore keeps wrap bit, queue full again", st(0, 0, 0, 1, 0, 0, 1, 0));

        // R9: step on a full B-to-A queue
        do_reset();
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, 0, 4'h0);
        cyc(0, 0, 0, 0, 4'h9);
        chk("R9 write step on full ignored", st(0, 0, 1, 0, 0, 0, 0, 1));

        // R1: hardware reset also clears the saved pointers
        do_reset();
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 4'h0);
        cyc(0, 0, 0, 0, 4'h5);
        cyc(1, 0, 0, 0, 4'h0);
        cyc(0, 0, 0, 0, 4'h4);
        chk("R6 state before reset", st(1, 0, 0, 0, 3, 0, 0, 0));
        do_reset();
        chk("R1 reset mid-run", st(0, 0, 1, 0, 0, 0, 1, 0));
        cyc(1, 0, 0, 0, 4'h7);
        chk("R1 rewrite mark cleared by reset", st(1, 0, 0, 0, 0, 0, 1, 0));

        // R10: clear both queues at once
        cyc(1, 0, 1, 0, 4'h0);
        cyc(0, 0, 1, 0, 4'h0);
        chk("R2 before clear-all", st(2, 0, 0, 0, 2, 0, 0, 0));
        cyc(1, 0, 1, 1, 4'h3);
        chk("R10 clear both", st(0, 0, 1, 0, 0, 0, 1, 0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule